// File: doc/BRIEF.md
# Four-Channel Playback Sequencer

This block holds the control state of four independent audio playback channels. A host strobes one of seven commands (play a phrase, preselect a phrase, start the preselected phrase, stop, insert silence, begin repeat, end repeat) together with a channel mask. Each selected channel accepts the command or ignores it according to its own state. Through a request/acknowledge pair the channel asks an external phrase reader to fetch a phrase, and a done pulse from that reader ends each pass.

Each channel reports two flags. `ready` (high = a new command may be given) and `busy_n` (active low, low whenever the channel is not idle). While a phrase or silence plays, the channel opens a follow-on window of a fixed number of 1 ms ticks. A phrase or silence given inside that window is queued, one deep, and starts the moment the current segment ends. When the window closes with nothing queued, the channel goes idle at the end of the segment. Silence gaps are counted in 1 ms ticks. A playing phrase may be set to repeat. Repeat can be released gracefully, so the current pass completes, or cut off at once by stop.

Top module: `pbseq_top`

## Requirements
- R1: After reset every channel shows `ready`=1 and `busy_n`=1, and `rd_req`=0.
- R2: A play command to an idle channel raises that channel's `rd_req` and drops `ready` and `busy_n` on the next cycle, with the commanded phrase on its `rd_phrase` field (bits i*PW upward). One cycle after `rd_ack`, `ready` is 1 again while `busy_n` stays 0.
- R3: Start plays the phrase last given by set-phrase. Start on a channel that has never received a set-phrase is ignored, and set-phrase on its own does not start playback.
- R4: Play, set-phrase, silence-insert and loop-set are ignored while the channel's `ready` is 0.
- R5: A play or silence-insert accepted while a segment plays is queued. `ready` then drops, and the queued item begins in the cycle after the segment's end (`rd_done`, or the last silence tick). With nothing queued, the channel goes idle there.
- R6: During playback `ready` stays 1 for exactly FOLLOW_MS ms ticks after the segment starts and then drops. A later follow-on is ignored, and the channel idles when the segment ends.
- R7: Silence code n, for n of 4 or more, lasts (n+1)*4 ms ticks. Codes 0 to 3 last 20 ticks.
- R8: Loop-set while a phrase plays drops `ready`, and every `rd_done` re-requests the same phrase. Loop-set during silence is ignored.
- R9: Loop-clear lets the current pass finish and then the channel goes idle without a further request. A loop-clear with an all-zero mask is ignored.
- R10: Stop, from any state, makes `ready`=1, `busy_n`=1 and `rd_req`=0 on the next cycle and discards any queued item.
- R11: Each command acts on exactly the channels whose mask bit is set, and on all of them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_play | input | 1 | Play the phrase on cmd_phrase |
| cmd_fadr | input | 1 | Preselect the phrase on cmd_phrase |
| cmd_start | input | 1 | Play the preselected phrase |
| cmd_stop | input | 1 | Stop at once |
| cmd_muon | input | 1 | Insert silence of code cmd_sil |
| cmd_sloop | input | 1 | Set repeat playback |
| cmd_cloop | input | 1 | Release repeat playback |
| cmd_mask | input | NCH | Channel select, bit i = channel i |
| cmd_phrase | input | PW | Phrase index |
| cmd_sil | input | SCW | Silence length code |
| ms_tick | input | 1 | One-cycle pulse every 1 ms |
| rd_ack | input | NCH | Reader accepted the fetch for channel i |
| rd_done | input | NCH | Reader finished the phrase for channel i |
| rd_req | output | NCH | Fetch request per channel |
| rd_phrase | output | NCH*PW | Phrase per channel, channel i at bits i*PW |
| ready | output | NCH | Next command may be given |
| busy_n | output | NCH | Active-low channel busy |

## Verification
The hold and no-effect properties assume that in the cycle being judged the reader raises neither `rd_ack` nor `rd_done` for the channel and `ms_tick` is low, because each of those can legally change the flags. The zero-mask release property also assumes that no other command strobe is present. The stimulus issues one command strobe per command cycle and drives the reader pulses in their own cycles. The 1 ms tick is switched off in every test except the window and silence-length sweeps.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_PLAY = 3'd2,
        ST_SIL  = 3'd3,
        ST_LOOP = 3'd4
    } chan_st_e;

    typedef struct packed {
        logic play;
        logic fadr;
        logic start;
        logic stop;
        logic muon;
        logic sloop;
        logic cloop;
    } cmd_t;

endpackage

// File: rtl/pbseq_sil_len.sv
module pbseq_sil_len #(
    parameter int SCW     = 8,
    parameter int SIL_MIN = 4,
    parameter int STEP_MS = 4,
    parameter int LW      = 11
) (
    input  logic [SCW-1:0] code,
    output logic [LW-1:0]  len_ms
);
    logic [SCW-1:0] eff;

    always_comb begin
        eff    = (code < SCW'(SIL_MIN)) ? SCW'(SIL_MIN) : code;
        len_ms = LW'((32'(eff) + 32'd1) * 32'(STEP_MS));
    end
endmodule

// File: rtl/pbseq_chan.sv
module pbseq_chan
    import pbseq_pkg::*;
#(
    parameter int PW        = 12,
    parameter int LW        = 11,
    parameter int FOLLOW_MS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_t          cmd,
    input  logic [PW-1:0] cmd_phrase,
    input  logic [LW-1:0] sil_len,
    input  logic          ms_tick,
    input  logic          rd_ack,
    input  logic          rd_done,
    output logic          rd_req,
    output logic [PW-1:0] rd_phrase,
    output logic          ready,
    output logic          busy_n
);
    localparam int WW = $clog2(FOLLOW_MS + 1);

    typedef struct packed {
        chan_st_e      st;
        logic [PW-1:0] cur;
        logic [PW-1:0] pre;
        logic          pre_vld;
        logic          q_vld;
        logic          q_sil;
        logic [PW-1:0] q_ph;
        logic [LW-1:0] q_len;
        logic [LW-1:0] sil_cnt;
        logic [WW-1:0] win_cnt;
        logic          win_open;
        logic          looping;
    } ch_t;

    ch_t q, d;
    logic          seg_end;
    logic          ready_c;
    logic          launch;
    logic          is_sil;
    logic          seg_run;
    logic [PW-1:0] pick;

    always_comb begin
        d       = q;
        seg_end = 1'b0;
        seg_run = (q.st == ST_PLAY) || (q.st == ST_SIL);
        ready_c = (q.st == ST_IDLE) || (seg_run && q.win_open && !q.q_vld);
        launch  = cmd.play || cmd.muon || (cmd.start && q.pre_vld);
        is_sil  = !cmd.play && cmd.muon;
        pick    = cmd.play ? cmd_phrase : q.pre;

        // progression of the running segment
        case (q.st)
            ST_ADDR: begin
                if (rd_ack) begin
                    d.st      = q.looping ? ST_LOOP : ST_PLAY;
                    d.win_cnt = '0;
                end
            end
            ST_PLAY: seg_end = rd_done;
            ST_SIL: begin
                if (ms_tick) begin
                    if (q.sil_cnt <= LW'(1)) seg_end = 1'b1;
                    else d.sil_cnt = q.sil_cnt - 1'b1;
                end
            end
            ST_LOOP: begin
                if (rd_done) d.st = ST_ADDR;
            end
            default: ;
        endcase

        // follow-on window
        if (seg_run && q.win_open && ms_tick) begin
            if (q.win_cnt == WW'(FOLLOW_MS - 1)) d.win_open = 1'b0;
            else d.win_cnt = q.win_cnt + 1'b1;
        end

        // ready-gated commands
        if (ready_c) begin
            if (cmd.fadr) begin
                d.pre     = cmd_phrase;
                d.pre_vld = 1'b1;
            end
            if (launch) begin
                if (q.st == ST_IDLE) begin
                    d.st       = is_sil ? ST_SIL : ST_ADDR;
                    d.cur      = is_sil ? q.cur : pick;
                    d.sil_cnt  = sil_len;
                    d.win_open = 1'b1;
                    d.win_cnt  = '0;
                    d.looping  = 1'b0;
                end else begin
                    d.q_vld = 1'b1;
                    d.q_sil = is_sil;
                    d.q_ph  = pick;
                    d.q_len = sil_len;
                end
            end else if (cmd.sloop && (q.st == ST_PLAY) && !seg_end) begin
                d.st       = ST_LOOP;
                d.looping  = 1'b1;
                d.win_open = 1'b0;
            end
        end

        // end of segment: launch queued item or go idle
        if (seg_end) begin
            if (d.q_vld) begin
                d.st       = d.q_sil ? ST_SIL : ST_ADDR;
                d.cur      = d.q_sil ? d.cur : d.q_ph;
                d.sil_cnt  = d.q_len;
                d.q_vld    = 1'b0;
                d.win_open = 1'b1;
                d.win_cnt  = '0;
            end else begin
                d.st       = ST_IDLE;
                d.win_open = 1'b0;
            end
        end

        // ungated commands, highest priority
        if (cmd.stop) begin
            d.st       = ST_IDLE;
            d.q_vld    = 1'b0;
            d.looping  = 1'b0;
            d.win_open = 1'b0;
        end else if (cmd.cloop && q.looping) begin
            d.looping  = 1'b0;
            d.win_open = 1'b0;
            if (q.st == ST_LOOP) d.st = rd_done ? ST_IDLE : ST_PLAY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req    = (q.st == ST_ADDR);
    assign rd_phrase = q.cur;
    assign ready     = ready_c;
    assign busy_n    = (q.st == ST_IDLE);
endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
    import pbseq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int PW        = 12,
    parameter int SCW       = 8,
    parameter int SIL_MIN   = 4,
    parameter int STEP_MS   = 4,
    parameter int FOLLOW_MS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_play,
    input  logic              cmd_fadr,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_muon,
    input  logic              cmd_sloop,
    input  logic              cmd_cloop,
    input  logic [NCH-1:0]    cmd_mask,
    input  logic [PW-1:0]     cmd_phrase,
    input  logic [SCW-1:0]    cmd_sil,
    input  logic              ms_tick,
    input  logic [NCH-1:0]    rd_ack,
    input  logic [NCH-1:0]    rd_done,
    output logic [NCH-1:0]    rd_req,
    output logic [NCH*PW-1:0] rd_phrase,
    output logic [NCH-1:0]    ready,
    output logic [NCH-1:0]    busy_n
);
    localparam int LW = $clog2((1 << SCW) * STEP_MS + 1);

    logic [LW-1:0] sil_len;

    pbseq_sil_len #(
        .SCW(SCW), .SIL_MIN(SIL_MIN), .STEP_MS(STEP_MS), .LW(LW)
    ) u_len (
        .code   (cmd_sil),
        .len_ms (sil_len)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmd_t c;
        assign c.play  = cmd_play  & cmd_mask[i];
        assign c.fadr  = cmd_fadr  & cmd_mask[i];
        assign c.start = cmd_start & cmd_mask[i];
        assign c.stop  = cmd_stop  & cmd_mask[i];
        assign c.muon  = cmd_muon  & cmd_mask[i];
        assign c.sloop = cmd_sloop & cmd_mask[i];
        assign c.cloop = cmd_cloop & cmd_mask[i];

        pbseq_chan #(
            .PW(PW), .LW(LW), .FOLLOW_MS(FOLLOW_MS)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (c),
            .cmd_phrase (cmd_phrase),
            .sil_len    (sil_len),
            .ms_tick    (ms_tick),
            .rd_ack     (rd_ack[i]),
            .rd_done    (rd_done[i]),
            .rd_req     (rd_req[i]),
            .rd_phrase  (rd_phrase[i*PW +: PW]),
            .ready      (ready[i]),
            .busy_n     (busy_n[i])
        );
    end
endmodule

// File: rtl/pbseq_chk.sv
module pbseq_chk #(
    parameter int NCH = 4,
    parameter int PW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_play,
    input logic              cmd_fadr,
    input logic              cmd_start,
    input logic              cmd_stop,
    input logic              cmd_muon,
    input logic              cmd_sloop,
    input logic              cmd_cloop,
    input logic [NCH-1:0]    cmd_mask,
    input logic              ms_tick,
    input logic [NCH-1:0]    rd_ack,
    input logic [NCH-1:0]    rd_done,
    input logic [NCH-1:0]    rd_req,
    input logic [NCH*PW-1:0] rd_phrase,
    input logic [NCH-1:0]    ready,
    input logic [NCH-1:0]    busy_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
            busy_n[i] |-> (ready[i] && !rd_req[i])); // R1

        AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[i] |-> (!ready[i] && !busy_n[i])); // R2

        AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy_n[i]) |-> $past(cmd_mask[i] && (cmd_play || cmd_start || cmd_muon))); // R2

        AST_NOTREADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd_play || cmd_start || cmd_muon) && cmd_mask[i] && !ready[i] &&
             !cmd_stop && !cmd_cloop && !ms_tick && !rd_ack[i] && !rd_done[i])
            |=> ($stable(busy_n[i]) && $stable(rd_req[i]) &&
                 $stable(rd_phrase[i*PW +: PW]))); // R4

        AST_ZERO_CLOOP: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_cloop && (cmd_mask == '0) && !cmd_play && !cmd_fadr && !cmd_start &&
             !cmd_stop && !cmd_muon && !cmd_sloop && !ms_tick && !rd_ack[i] && !rd_done[i])
            |=> ($stable(ready[i]) && $stable(busy_n[i]) && $stable(rd_req[i]))); // R9

        AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_stop && cmd_mask[i]) |=> (ready[i] && busy_n[i] && !rd_req[i])); // R10
    end
endmodule

bind pbseq_top pbseq_chk #(.NCH(NCH), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_play  (cmd_play),
    .cmd_fadr  (cmd_fadr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_muon  (cmd_muon),
    .cmd_sloop (cmd_sloop),
    .cmd_cloop (cmd_cloop),
    .cmd_mask  (cmd_mask),
    .ms_tick   (ms_tick),
    .rd_ack    (rd_ack),
    .rd_done   (rd_done),
    .rd_req    (rd_req),
    .rd_phrase (rd_phrase),
    .ready     (ready),
    .busy_n    (busy_n)
);

// File: tb/sim_pbseq_top.sv
module sim_pbseq_top;
    localparam int NCH = 4;
    localparam int PW  = 12;
    localparam int FOLLOW_MS = 8;

    localparam int K_PLAY  = 0;
    localparam int K_FADR  = 1;
    localparam int K_START = 2;
    localparam int K_STOP  = 3;
    localparam int K_MUON  = 4;
    localparam int K_SLOOP = 5;
    localparam int K_CLOOP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_play = 0, cmd_fadr = 0, cmd_start = 0, cmd_stop = 0;
    logic cmd_muon = 0, cmd_sloop = 0, cmd_cloop = 0;
    logic [NCH-1:0] cmd_mask = '0;
    logic [PW-1:0]  cmd_phrase = '0;
    logic [7:0]     cmd_sil = '0;
    logic           ms_tick = 1'b0;
    logic [NCH-1:0] rd_ack = '0;
    logic [NCH-1:0] rd_done = '0;
    logic [NCH-1:0] rd_req;
    logic [NCH*PW-1:0] rd_phrase;
    logic [NCH-1:0] ready;
    logic [NCH-1:0] busy_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic tick_en = 1'b0;
    logic tph = 1'b0;

    pbseq_top #(.NCH(NCH), .PW(PW), .FOLLOW_MS(FOLLOW_MS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_play(cmd_play), .cmd_fadr(cmd_fadr), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_muon(cmd_muon), .cmd_sloop(cmd_sloop),
        .cmd_cloop(cmd_cloop), .cmd_mask(cmd_mask), .cmd_phrase(cmd_phrase),
        .cmd_sil(cmd_sil), .ms_tick(ms_tick), .rd_ack(rd_ack), .rd_done(rd_done),
        .rd_req(rd_req), .rd_phrase(rd_phrase), .ready(ready), .busy_n(busy_n)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (tick_en) begin
            tph = ~tph;
            ms_tick = tph;
        end else begin
            ms_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input int k, input logic [3:0] m, input logic [11:0] ph,
                         input logic [7:0] sc);
        @(negedge clk);
        cmd_mask = m; cmd_phrase = ph; cmd_sil = sc;
        cmd_play = (k == K_PLAY);  cmd_fadr = (k == K_FADR);
        cmd_start = (k == K_START); cmd_stop = (k == K_STOP);
        cmd_muon = (k == K_MUON);  cmd_sloop = (k == K_SLOOP);
        cmd_cloop = (k == K_CLOOP);
        @(negedge clk);
        cmd_play = 0; cmd_fadr = 0; cmd_start = 0; cmd_stop = 0;
        cmd_muon = 0; cmd_sloop = 0; cmd_cloop = 0; cmd_mask = '0;
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk); rd_ack = m;
        @(negedge clk); rd_ack = '0;
    endtask

    task automatic done(input logic [3:0] m);
        @(negedge clk); rd_done = m;
        @(negedge clk); rd_done = '0;
    endtask

    function automatic logic [11:0] ph_of(input int i);
        return rd_phrase[i*PW +: PW];
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", 32'(ready), 32'hF);
        chk("R1 busy_n", 32'(busy_n), 32'hF);
        chk("R1 rd_req", 32'(rd_req), 32'h0);

        // R2 play from idle
        issue(K_PLAY, 4'b0001, 12'h123, 8'd0);
        chk("R2 rd_req", 32'(rd_req), 32'h1);
        chk("R2 ready low", 32'(ready[0]), 32'h0);
        chk("R2 busy low", 32'(busy_n[0]), 32'h0);
        chk("R2 phrase", 32'(ph_of(0)), 32'h123);
        ack(4'b0001);
        chk("R2 ready after ack", 32'(ready[0]), 32'h1);
        chk("R2 busy after ack", 32'(busy_n[0]), 32'h0);
        chk("R2 req after ack", 32'(rd_req[0]), 32'h0);

        // R5 queued follow-on
        issue(K_PLAY, 4'b0001, 12'h055, 8'd0);
        chk("R5 ready drops when queued", 32'(ready[0]), 32'h0);
        chk("R5 no request yet", 32'(rd_req[0]), 32'h0);
        done(4'b0001);
        chk("R5 queued launch", 32'(rd_req[0]), 32'h1);
        chk("R5 queued phrase", 32'(ph_of(0)), 32'h055);
        ack(4'b0001);
        done(4'b0001);
        chk("R5 idle after empty queue", 32'(busy_n[0]), 32'h1);

        // R4 commands ignored while not ready
        issue(K_PLAY, 4'b0010, 12'h010, 8'd0);
        issue(K_PLAY, 4'b0010, 12'h020, 8'd0);
        chk("R4 phrase unchanged", 32'(ph_of(1)), 32'h010);
        issue(K_MUON, 4'b0010, 12'h000, 8'd9);
        chk("R4 still requesting", 32'(rd_req[1]), 32'h1);
        ack(4'b0010);
        done(4'b0010);
        chk("R4 nothing was queued", 32'(busy_n[1]), 32'h1);

        // R3 set-phrase and start
        issue(K_START, 4'b0100, 12'h000, 8'd0);
        chk("R3 start without preselect", 32'(busy_n[2]), 32'h1);
        issue(K_FADR, 4'b0100, 12'h3AB, 8'd0);
        chk("R3 preselect does not start", 32'(busy_n[2]), 32'h1);
        issue(K_START, 4'b0100, 12'h000, 8'd0);
        chk("R3 start request", 32'(rd_req[2]), 32'h1);
        chk("R3 start phrase", 32'(ph_of(2)), 32'h3AB);
        issue(K_STOP, 4'b0100, 12'h000, 8'd0);

        // R8 repeat playback
        issue(K_PLAY, 4'b1000, 12'h0F0, 8'd0);
        ack(4'b1000);
        issue(K_SLOOP, 4'b1000, 12'h000, 8'd0);
        chk("R8 ready low while looping", 32'(ready[3]), 32'h0);
        done(4'b1000);
        chk("R8 refetch", 32'(rd_req[3]), 32'h1);
        chk("R8 same phrase", 32'(ph_of(3)), 32'h0F0);
        ack(4'b1000);
        done(4'b1000);
        chk("R8 second refetch", 32'(rd_req[3]), 32'h1);
        ack(4'b1000);

        // R9 zero-mask release ignored, then graceful release
        issue(K_CLOOP, 4'b0000, 12'h000, 8'd0);
        done(4'b1000);
        chk("R9 zero mask keeps looping", 32'(rd_req[3]), 32'h1);
        ack(4'b1000);
        issue(K_CLOOP, 4'b1000, 12'h000, 8'd0);
        chk("R9 pass continues", 32'(busy_n[3]), 32'h0);
        done(4'b1000);
        chk("R9 idle after pass", 32'(busy_n[3]), 32'h1);
        chk("R9 no further request", 32'(rd_req[3]), 32'h0);

        // R8 loop-set during silence ignored
        issue(K_MUON, 4'b0001, 12'h000, 8'd10);
        chk("R8 silence running", 32'(busy_n[0]), 32'h0);
        issue(K_SLOOP, 4'b0001, 12'h000, 8'd0);
        chk("R8 sloop in silence ignored", 32'(ready[0]), 32'h1);

        // R10 stop from silence, with queue, during fetch
        issue(K_STOP, 4'b0001, 12'h000, 8'd0);
        chk("R10 stop silence", 32'(busy_n[0]), 32'h1);
        issue(K_PLAY, 4'b0010, 12'h044, 8'd0);
        ack(4'b0010);
        issue(K_PLAY, 4'b0010, 12'h045, 8'd0);
        chk("R10 queued before stop", 32'(ready[1]), 32'h0);
        issue(K_STOP, 4'b0010, 12'h000, 8'd0);
        chk("R10 ready", 32'(ready[1]), 32'h1);
        chk("R10 busy_n", 32'(busy_n[1]), 32'h1);
        done(4'b0010);
        chk("R10 queue discarded", 32'(rd_req[1]), 32'h0);
        issue(K_PLAY, 4'b0100, 12'h001, 8'd0);
        issue(K_STOP, 4'b0100, 12'h000, 8'd0);
        chk("R10 stop during fetch", 32'(rd_req[2]), 32'h0);

        // R11 multi-channel masks
        issue(K_PLAY, 4'b1111, 12'h200, 8'd0);
        chk("R11 all request", 32'(rd_req), 32'hF);
        for (int i = 0; i < NCH; i++) chk("R11 phrase per channel", 32'(ph_of(i)), 32'h200);
        ack(4'b0101);
        chk("R11 ready per channel", 32'(ready), 32'h5);
        issue(K_STOP, 4'b1010, 12'h000, 8'd0);
        chk("R11 stop subset", 32'(busy_n), 32'hA);
        issue(K_STOP, 4'b1111, 12'h000, 8'd0);
        chk("R11 all idle", 32'(busy_n), 32'hF);

        // R6 follow-on window
        issue(K_PLAY, 4'b0001, 12'h077, 8'd0);
        ack(4'b0001);
        tick_en = 1'b1;
        n = 0;
        while (ready[0] === 1'b1 && n < 100) begin
            @(posedge clk);
            if (ms_tick) n++;
            @(negedge clk);
        end
        chk("R6 window length", 32'(n), 32'(FOLLOW_MS));
        issue(K_PLAY, 4'b0001, 12'h078, 8'd0);
        chk("R6 late follow-on ignored", 32'(rd_req[0]), 32'h0);
        done(4'b0001);
        chk("R6 idle after window", 32'(busy_n[0]), 32'h1);

        // R7 silence length sweep
        for (int c = 0; c < 256; c = (c < 6) ? c + 1 : c + 31) begin
            int exp_len;
            exp_len = (((c < 4) ? 4 : c) + 1) * 4;
            issue(K_MUON, 4'b0010, 12'h000, 8'(c));
            n = 0;
            while (busy_n[1] === 1'b0 && n < 2000) begin
                @(posedge clk);
                if (ms_tick) n++;
                @(negedge clk);
            end
            chk("R7 silence length", 32'(n), 32'(exp_len));
        end
        issue(K_MUON, 4'b0010, 12'h000, 8'd255);
        n = 0;
        while (busy_n[1] === 1'b0 && n < 2000) begin
            @(posedge clk);
            if (ms_tick) n++;
            @(negedge clk);
        end
        chk("R7 longest silence", 32'(n), 32'd1024);

        // R5 R7 queued silence after a phrase
        tick_en = 1'b0;
        issue(K_PLAY, 4'b0100, 12'h0AA, 8'd0);
        ack(4'b0100);
        issue(K_MUON, 4'b0100, 12'h000, 8'd5);
        chk("R5 silence queued", 32'(ready[2]), 32'h0);
        tick_en = 1'b1;
        done(4'b0100);
        chk("R5 silence started", 32'(busy_n[2]), 32'h0);
        n = 0;
        while (busy_n[2] === 1'b0 && n < 2000) begin
            @(posedge clk);
            if (ms_tick) n++;
            @(negedge clk);
        end
        chk("R7 queued silence length", 32'(n), 32'd24);
        tick_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule